// File: doc/BRIEF.md
# Tagged Register Load Writeback

This block sits where load data returns to a 32-entry, 64-bit register file. Beside the register data it keeps one type bit per architectural register. A set bit marks a register that holds a floating-point value. A clear bit marks integer, address or any other non-floating content. Because the type travels with the register, later arithmetic can pick its unit from the tag and does not need separate opcodes per data type.

Each returning load brings a kind code, a signedness control, a destination index and 64 bits of raw memory data. The block shapes the data into its final register form and presents it one cycle later on a registered write port. A single-precision floating load is widened to double precision, so a tagged register always holds a double. A narrow integer load is sign- or zero-extended. Full-width loads pass through unchanged. The tag bit of the destination is updated on the same clock edge, set by the two floating kinds and cleared by the two integer kinds. A combinational read port returns the tag of any register for dispatch logic. Stores need no tag-aware variant and are not handled here.

Top module: `tagged_load_wb`

## Requirements
- R1: While reset is asserted and right after it, `wr_en` is low and every tag bit reads 0.
- R2: `tag_rd_val` is the tag of register `tag_rd_idx`, combinationally; a load accepted at one rising edge is visible there immediately after that edge.
- R3: A load of kind 2 (single floating) or kind 3 (double floating) to a writable register sets that register's tag to 1.
- R4: A load of kind 0 (32-bit integer) or kind 1 (64-bit integer) to a writable register clears that register's tag to 0.
- R5: Kind 2 widens bits [31:0] of `ld_data`: for a normal input the 8-bit exponent is increased by 896 into an 11-bit field and the 23-bit fraction is placed in bits [51:29] with zeros below; a signed zero stays a signed zero and an infinity stays an infinity of the same sign.
- R6: For a kind 2 NaN (exponent 255, fraction non-zero) the result has exponent 2047, the same sign, and the 23 input fraction bits unchanged in result bits [51:29].
- R7: For a kind 2 subnormal input the result is the equal normal double: the fraction is shifted left until its leading one drops out as the hidden bit, and the exponent is 896 minus the number of leading zeros of the 23-bit fraction.
- R8: For kind 0, `ld_signed`=1 copies bit 31 of `ld_data` into bits [63:32]; `ld_signed`=0 fills them with zeros.
- R9: Kinds 1 and 3 write `ld_data` unchanged; `ld_signed` has no effect on kinds 1, 2 and 3.
- R10: With `ZERO_REG_EN` set, a load to register 0 raises no write and leaves tag 0 at 0.
- R11: A load with `ld_valid` high at a rising edge appears on `wr_en`, `wr_addr`, `wr_data` right after that edge; with `ld_valid` low `wr_en` is low the next cycle and no tag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A returning load is present this cycle |
| ld_kind | input | 2 | 0 int32, 1 int64, 2 single float, 3 double float |
| ld_signed | input | 1 | Sign-extend a 32-bit integer load when high |
| ld_dest | input | 5 | Destination register index |
| ld_data | input | 64 | Raw memory data, narrow loads in bits [31:0] |
| tag_rd_idx | input | 5 | Register index for the tag read port |
| tag_rd_val | output | 1 | Tag of register `tag_rd_idx` |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | 5 | Register file write index |
| wr_data | output | 64 | Register file write value |

## Verification
The properties take for granted that every input carries a defined value whenever `ld_valid` is high, that the kind code is one of the four listed, and that reset is asserted before the first load; they do not assume anything about the order or spacing of loads. The stimulus changes inputs only at falling edges, holds `ld_valid` low outside a load, and always drives all four fields, mixing directed patterns (signed zeros, infinities, quiet and signalling NaNs, the smallest and largest subnormals, negative 32-bit integers) with a long run of random loads that include register 0 and back-to-back writes to the same register.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    localparam int DATA_W     = 64;
    localparam int NARROW_W   = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int EXP_REBIAS = 896;
    localparam int FRAC_PAD   = DP_FRAC_W - SP_FRAC_W;
    localparam int LZ_W       = $clog2(SP_FRAC_W + 1);

    typedef enum logic [1:0] {
        LK_INT32 = 2'd0,
        LK_INT64 = 2'd1,
        LK_FP32  = 2'd2,
        LK_FP64  = 2'd3
    } load_kind_e;

    function automatic logic kind_is_float(input load_kind_e k);
        return (k == LK_FP32) || (k == LK_FP64);
    endfunction

endpackage

// File: rtl/tlw_fp_widen.sv
module tlw_fp_widen
    import tlw_pkg::*;
(
    input  logic [NARROW_W-1:0] sp_in,
    output logic [DATA_W-1:0]   dp_out
);

    localparam logic [SP_EXP_W-1:0] SP_EXP_MAX = '1;
    localparam logic [DP_EXP_W-1:0] DP_EXP_MAX = '1;
    localparam logic [DP_EXP_W-1:0] REBIAS     = DP_EXP_W'(EXP_REBIAS);

    logic                  sgn;
    logic [SP_EXP_W-1:0]   sexp;
    logic [SP_FRAC_W-1:0]  sfrac;
    logic [LZ_W-1:0]       lz;
    logic [LZ_W-1:0]       shamt;
    logic [SP_FRAC_W-1:0]  norm_frac;
    logic [DP_EXP_W-1:0]   dexp;
    logic [SP_FRAC_W-1:0]  dfrac_hi;

    assign sgn   = sp_in[NARROW_W-1];
    assign sexp  = sp_in[NARROW_W-2 -: SP_EXP_W];
    assign sfrac = sp_in[SP_FRAC_W-1:0];

    // leading-zero count of the single-precision fraction
    always_comb begin
        logic found;
        found = 1'b0;
        lz    = '0;
        for (int i = SP_FRAC_W - 1; i >= 0; i--) begin
            if (!found && sfrac[i]) begin
                found = 1'b1;
                lz    = LZ_W'(SP_FRAC_W - 1 - i);
            end
        end
    end

    assign shamt     = lz + LZ_W'(1);
    assign norm_frac = sfrac << shamt;

    always_comb begin
        if (sexp == SP_EXP_MAX) begin
            dexp     = DP_EXP_MAX;
            dfrac_hi = sfrac;
        end else if (sexp == '0 && sfrac == '0) begin
            dexp     = '0;
            dfrac_hi = '0;
        end else if (sexp == '0) begin
            dexp     = REBIAS - DP_EXP_W'(lz);
            dfrac_hi = norm_frac;
        end else begin
            dexp     = DP_EXP_W'(sexp) + REBIAS;
            dfrac_hi = sfrac;
        end
    end

    assign dp_out = {sgn, dexp, dfrac_hi, {FRAC_PAD{1'b0}}};

endmodule

// File: rtl/tlw_int_extend.sv
module tlw_int_extend
    import tlw_pkg::*;
(
    input  load_kind_e        kind,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] value
);

    localparam int EXT_W = DATA_W - NARROW_W;

    logic              fill_bit;
    logic [DATA_W-1:0] narrow_ext;

    assign fill_bit   = is_signed & raw[NARROW_W-1];
    assign narrow_ext = {{EXT_W{fill_bit}}, raw[NARROW_W-1:0]};

    always_comb begin
        unique case (kind)
            LK_INT32: value = narrow_ext;
            default:  value = raw;
        endcase
    end

endmodule

// File: rtl/tlw_tag_file.sv
module tlw_tag_file #(
    parameter int NREG  = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_tag
);

    typedef struct packed {
        logic [NREG-1:0] tags;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tags[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_tag = st_q.tags[rd_idx];

    p_float_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tag) |=> st_q.tags[$past(wr_idx)])
        else $error("float load did not set tag");

    p_int_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_tag) |=> !st_q.tags[$past(wr_idx)])
        else $error("integer load did not clear tag");

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.tags))
        else $error("tag changed without a write");

    p_single_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($countones(st_q.tags ^ $past(st_q.tags)) <= 1))
        else $error("more than one tag changed");

endmodule

// File: rtl/tagged_load_wb.sv
module tagged_load_wb
    import tlw_pkg::*;
#(
    parameter int NREG        = 32,
    parameter bit ZERO_REG_EN = 1'b1,
    localparam int IDX_W      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [1:0]        ld_kind,
    input  logic              ld_signed,
    input  logic [IDX_W-1:0]  ld_dest,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  tag_rd_idx,
    output logic              tag_rd_val,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wb_state_t;

    wb_state_t wb_d, wb_q;

    load_kind_e        kind;
    logic [DATA_W-1:0] widened;
    logic [DATA_W-1:0] extended;
    logic              dest_writable;
    logic              commit;

    assign kind = load_kind_e'(ld_kind);

    tlw_fp_widen u_widen (
        .sp_in  (ld_data[NARROW_W-1:0]),
        .dp_out (widened)
    );

    tlw_int_extend u_extend (
        .kind      (kind),
        .is_signed (ld_signed),
        .raw       (ld_data),
        .value     (extended)
    );

    generate
        if (ZERO_REG_EN) begin : g_zero_reg
            assign dest_writable = (ld_dest != '0);
        end else begin : g_no_zero_reg
            assign dest_writable = 1'b1;
        end
    endgenerate

    assign commit = ld_valid && dest_writable;

    always_comb begin
        wb_d      = wb_q;
        wb_d.en   = commit;
        if (commit) begin
            wb_d.addr = ld_dest;
            wb_d.data = (kind == LK_FP32) ? widened : extended;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    tlw_tag_file #(.NREG(NREG)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit),
        .wr_idx (ld_dest),
        .wr_tag (kind_is_float(kind)),
        .rd_idx (tag_rd_idx),
        .rd_tag (tag_rd_val)
    );

    assign wr_en   = wb_q.en;
    assign wr_addr = wb_q.addr;
    assign wr_data = wb_q.data;

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !wr_en)
        else $error("write without a load");

    p_addr_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_dest != '0) |=> (wr_en && wr_addr == $past(ld_dest)))
        else $error("write port did not follow load");

    p_zero_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_REG_EN && ld_valid && ld_dest == '0) |=> !wr_en)
        else $error("register 0 was written");

    p_full_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_dest != '0 && ld_kind[0]) |=> (wr_data == $past(ld_data)))
        else $error("full-width load altered");

    p_tag_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_dest != '0 && tag_rd_idx == ld_dest) |=>
            ($stable(tag_rd_idx) -> (tag_rd_val == $past(ld_kind[1]))))
        else $error("tag read stale");

endmodule

// File: tb/tagged_load_wb_bench.sv
`timescale 1ns/1ps
module tagged_load_wb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_kind = 2'd0;
    logic        ld_signed = 1'b0;
    logic [4:0]  ld_dest = 5'd0;
    logic [63:0] ld_data = 64'd0;
    logic [4:0]  tag_rd_idx = 5'd0;
    logic        tag_rd_val;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] wr_data;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  mtag [32];

    always #2 clk = ~clk;

    tagged_load_wb u_tagged_load_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .ld_kind    (ld_kind),
        .ld_signed  (ld_signed),
        .ld_dest    (ld_dest),
        .ld_data    (ld_data),
        .tag_rd_idx (tag_rd_idx),
        .tag_rd_val (tag_rd_val),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural single -> double conversion, iterative normalisation
    function automatic logic [63:0] ref_widen(input logic [31:0] x);
        logic        s;
        int          e;
        logic [23:0] m;
        s = x[31];
        e = int'(x[30:23]);
        m = {1'b0, x[22:0]};
        if (e == 255) return {s, 11'h7ff, x[22:0], 29'd0};
        if (e == 0 && m == 0) return {s, 63'd0};
        if (e == 0) begin
            e = -126;
            while (!m[23]) begin
                m = m << 1;
                e = e - 1;
            end
            return {s, 11'(e + 1023), m[22:0], 29'd0};
        end
        return {s, 11'(e - 127 + 1023), x[22:0], 29'd0};
    endfunction

    function automatic logic [63:0] ref_value(input logic [1:0] k, input bit sg,
                                              input logic [63:0] x);
        case (k)
            2'd0:    return sg ? {{32{x[31]}}, x[31:0]} : {32'd0, x[31:0]};
            2'd2:    return ref_widen(x[31:0]);
            default: return x;
        endcase
    endfunction

    task automatic do_load(input bit v, input logic [1:0] k, input bit sg,
                           input logic [4:0] d, input logic [63:0] x, input string req);
        bit          e_en;
        logic [63:0] e_data;
        @(negedge clk);
        ld_valid   = v;
        ld_kind    = k;
        ld_signed  = sg;
        ld_dest    = d;
        ld_data    = x;
        tag_rd_idx = d;
        @(posedge clk);
        e_en   = v && (d != 5'd0);
        e_data = ref_value(k, sg, x);
        if (e_en) mtag[d] = k[1];
        #1;
        chk(wr_en === e_en, req, "wr_en", 64'(wr_en), 64'(e_en));
        if (e_en) begin
            chk(wr_addr === d, req, "wr_addr", 64'(wr_addr), 64'(d));
            chk(wr_data === e_data, req, "wr_data", wr_data, e_data);
        end
        chk(tag_rd_val === mtag[d], "R2", "tag after load", 64'(tag_rd_val), 64'(mtag[d]));
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic sweep_tags(input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ld_valid   = 1'b0;
            tag_rd_idx = 5'(i);
            #1;
            chk(tag_rd_val === mtag[i], req, "tag sweep", 64'(tag_rd_val), 64'(mtag[i]));
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mtag[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_en === 1'b0, "R1", "wr_en in reset", 64'(wr_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en === 1'b0, "R1", "wr_en after reset", 64'(wr_en), 64'd0);
        sweep_tags("R1");

        // R5 normal, zero, infinity
        do_load(1, 2'd2, 0, 5'd1, 64'h0000_0000_3F80_0000, "R5");
        do_load(1, 2'd2, 0, 5'd2, 64'hFFFF_FFFF_C020_0000, "R5");
        do_load(1, 2'd2, 0, 5'd3, 64'h0000_0000_8000_0000, "R5");
        do_load(1, 2'd2, 0, 5'd4, 64'h0000_0000_7F80_0000, "R5");
        do_load(1, 2'd2, 1, 5'd5, 64'h0000_0000_FF7F_FFFF, "R5");
        do_load(1, 2'd2, 0, 5'd6, 64'h0000_0000_0080_0000, "R5");
        // R6 NaNs
        do_load(1, 2'd2, 0, 5'd7, 64'h0000_0000_7FC1_2345, "R6");
        do_load(1, 2'd2, 0, 5'd8, 64'h0000_0000_FF80_0001, "R6");
        // R7 subnormals
        do_load(1, 2'd2, 0, 5'd9,  64'h0000_0000_0000_0001, "R7");
        do_load(1, 2'd2, 0, 5'd10, 64'h0000_0000_0040_0000, "R7");
        do_load(1, 2'd2, 0, 5'd11, 64'h0000_0000_8000_0003, "R7");
        do_load(1, 2'd2, 0, 5'd12, 64'h0000_0000_007F_FFFF, "R7");
        // R8 narrow integers
        do_load(1, 2'd0, 1, 5'd13, 64'hDEAD_BEEF_8000_0001, "R8");
        do_load(1, 2'd0, 0, 5'd14, 64'hDEAD_BEEF_8000_0001, "R8");
        do_load(1, 2'd0, 1, 5'd15, 64'h1234_5678_7FFF_FFFF, "R8");
        // R9 full width, signedness ignored
        do_load(1, 2'd1, 1, 5'd16, 64'h8000_0000_8000_0000, "R9");
        do_load(1, 2'd3, 1, 5'd17, 64'hFFF8_0000_0000_0001, "R9");
        // R4 integer loads clear a set tag, R3 float sets it again
        do_load(1, 2'd0, 0, 5'd1, 64'h0000_0000_0000_0005, "R4");
        do_load(1, 2'd1, 0, 5'd2, 64'h0000_0000_0000_0006, "R4");
        do_load(1, 2'd3, 0, 5'd1, 64'h4000_0000_0000_0000, "R3");
        // R10 register zero
        do_load(1, 2'd3, 0, 5'd0, 64'h4000_0000_0000_0000, "R10");
        do_load(1, 2'd2, 0, 5'd0, 64'h0000_0000_3F80_0000, "R10");
        // R11 idle cycles
        do_load(0, 2'd3, 0, 5'd20, 64'h1, "R11");
        do_load(0, 2'd2, 0, 5'd1, 64'h1, "R11");
        sweep_tags("R11");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [63:0] x;
            logic [1:0]  k;
            x = {$urandom, $urandom};
            k = 2'($urandom % 4);
            if (k == 2'd2 && ($urandom % 3) == 0) x[30:23] = ($urandom % 2) ? 8'hFF : 8'h00;
            do_load(($urandom % 8) != 0, k, 1'($urandom % 2), 5'($urandom % 32), x, "R3");
        end
        sweep_tags("R2");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule